// File: doc/BRIEF.md
# Monitor Sync Input Processor

This block conditions the two digital sync lines of a display monitor before they reach the deflection timing loops. The first line carries horizontal sync or composite sync; the second carries a separate vertical sync. Each line is brought into the system clock domain and its polarity is found from the ratio of high time to low time. It is then inverted where needed, so that every later stage works on active-high pulses.

From the horizontal or composite line the block produces a one-cycle line strobe at a fixed delay after each accepted leading edge. It rejects pulses narrower than a programmable minimum. It drops pulses that arrive too soon after the previous strobe, which removes the equalizing pulses at twice the line rate. A running duty integrator classifies the composite signal. When the pulse content rises above a quarter of the time, a vertical interval has been extracted. During that interval a PLL-inhibit window is held, and a frame strobe marks its start.

Firmware reads three sticky presence flags and the two polarity flags. It sets the source select from them, and it clears the flags through the refresh control before the next survey. All timing is counted in system clocks against the configuration inputs.

Top module: `sync_input_proc`

## Requirements
- R1: Both raw inputs pass through a two-register synchroniser. While reset is asserted and right after it, all strobes, the inhibit window, the polarity flags and the presence flags are 0.
- R2: A polarity flag is re-evaluated at each rising edge of its synchronised input. It becomes 1 (negative) when the last high phase was longer than the low phase that just ended, and 0 otherwise. The normalised pulse is the synchronised input XOR the flag.
- R3: `line_strobe` is a one-cycle pulse. It is issued once per normalised horizontal pulse, when that pulse has been high for exactly `cfg_min_width` consecutive clocks. A pulse shorter than `cfg_min_width` produces no strobe.
- R4: A horizontal pulse whose qualifying cycle comes fewer than `cfg_holdoff` clocks after the previous line strobe produces no strobe. This removes equalizing pulses.
- R5: A duty accumulator adds 3 for each clock the normalised horizontal/composite line is high and subtracts 1 for each low clock. It saturates at 0 and at its maximum, so it grows only while the duty exceeds 25%. The extracted vertical interval starts when the accumulator is at or above `cfg_vx_on` and ends when it returns to 0.
- R6: `pll_inhibit` equals the extracted vertical interval while `sel_separate` is 0 (composite). It stays 0 while `sel_separate` is 1.
- R7: With `sel_separate` = 1, `frame_strobe` fires once for each normalised vertical-input pulse that reaches `cfg_min_width` clocks, with no holdoff applied. With `sel_separate` = 0, it fires once at the start of each extracted vertical interval.
- R8: `hv_seen` is set by a line strobe. `v_seen` is set by a qualified vertical-input pulse. `vx_seen` is set at the start of an extracted vertical interval, whatever the value of `sel_separate`. Each flag stays set until a refresh.
- R9: A cycle with `det_refresh` = 1 clears all three presence flags in the next cycle. It takes priority over a set in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_raw | input | 1 | Horizontal or composite sync, either polarity |
| vsync_raw | input | 1 | Separate vertical sync, either polarity |
| sel_separate | input | 1 | 1 = separate H and V, 0 = composite |
| det_refresh | input | 1 | Clears the presence flags |
| cfg_min_width | input | CW | Minimum pulse width in clocks (>= 1) |
| cfg_holdoff | input | CW | Minimum spacing between line strobes in clocks |
| cfg_vx_on | input | AW | Accumulator level that starts an extracted vertical interval (>= 1) |
| line_strobe | output | 1 | One-cycle horizontal sync strobe |
| frame_strobe | output | 1 | One-cycle vertical sync strobe |
| pll_inhibit | output | 1 | Phase comparator inhibit during extracted vertical sync |
| hpol_neg | output | 1 | Horizontal input polarity, 1 = negative |
| vpol_neg | output | 1 | Vertical input polarity, 1 = negative |
| hv_seen | output | 1 | Sticky: horizontal sync seen |
| v_seen | output | 1 | Sticky: separate vertical sync seen |
| vx_seen | output | 1 | Sticky: vertical sync extracted from composite |

## Verification
Positive and negative line trains of the same width show that the polarity flag follows the shorter phase and that strobe counts do not depend on polarity. Pulses two clocks wide, one clock below the minimum and exactly at the minimum bracket the glitch threshold. A line period shorter than the holdoff stands in for equalizing pulses and must yield every other strobe. A composite train with a block of 37% duty lines, run once in each source mode, separates extraction and its flag, which do not depend on the mode, from the inhibit window and frame strobe, which do. Positive and negative vertical inputs, plus a vertical glitch, cover the separate-mode frame strobe.

// File: rtl/sync_proc_pkg.sv
package sync_proc_pkg;
  // duty accumulator steps: net growth only above 1/(1+3) = 25 % duty
  localparam int unsigned ACC_UP_STEP = 3;
  localparam int unsigned ACC_DN_STEP = 1;
  localparam int unsigned NUM_INPUTS  = 2;
  localparam int unsigned IDX_H       = 0;
  localparam int unsigned IDX_V       = 1;

  typedef enum logic {
    SRC_COMPOSITE = 1'b0,
    SRC_SEPARATE  = 1'b1
  } sync_src_e;
endpackage

// File: rtl/sync_in_cond.sv
module sync_in_cond #(
  parameter int unsigned CW = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic norm_out,
  output logic pol_neg
);
  localparam logic [CW-1:0] RUN_MAX = {CW{1'b1}};

  logic [1:0]    meta_q, meta_n;
  logic          prev_q;
  logic [CW-1:0] run_q, run_n;
  logic [CW-1:0] hi_len_q, hi_len_n;
  logic          pol_q, pol_n;
  logic          s_in, chg, rise;

  assign s_in = meta_q[1];
  assign chg  = s_in ^ prev_q;
  assign rise = s_in & ~prev_q;

  always_comb begin
    meta_n   = {meta_q[0], raw_in};
    run_n    = run_q;
    hi_len_n = hi_len_q;
    pol_n    = pol_q;
    if (chg) begin
      run_n = {{(CW-1){1'b0}}, 1'b1};
      if (prev_q) hi_len_n = run_q;
    end else if (run_q != RUN_MAX) begin
      run_n = run_q + 1'b1;
    end
    if (rise) pol_n = (hi_len_q > run_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      prev_q   <= 1'b0;
      run_q    <= '0;
      hi_len_q <= '0;
      pol_q    <= 1'b0;
    end else begin
      meta_q   <= meta_n;
      prev_q   <= s_in;
      run_q    <= run_n;
      hi_len_q <= hi_len_n;
      pol_q    <= pol_n;
    end
  end

  assign norm_out = s_in ^ pol_q;
  assign pol_neg  = pol_q;
endmodule

// File: rtl/sync_pulse_qual.sv
module sync_pulse_qual #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sig,
  input  logic [CW-1:0] min_w,
  input  logic [CW-1:0] holdoff,
  output logic          strobe
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] run_q, run_n;
  logic [CW-1:0] since_q, since_n;
  logic          fire, strobe_q;

  always_comb begin
    if (!sig)                run_n = '0;
    else if (run_q != CNT_MAX) run_n = run_q + 1'b1;
    else                     run_n = run_q;
    fire = sig && (run_n == min_w) && (since_q >= holdoff);
    if (fire)                  since_n = '0;
    else if (since_q != CNT_MAX) since_n = since_q + 1'b1;
    else                       since_n = since_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      since_q  <= CNT_MAX;
      strobe_q <= 1'b0;
    end else begin
      run_q    <= run_n;
      since_q  <= since_n;
      strobe_q <= fire;
    end
  end

  assign strobe = strobe_q;
endmodule

// File: rtl/sync_vert_extract.sv
module sync_vert_extract
  import sync_proc_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sig,
  input  logic [AW-1:0] on_level,
  output logic          active,
  output logic          start
);
  localparam logic [AW-1:0] ACC_MAX = {AW{1'b1}};
  localparam logic [AW-1:0] UP      = AW'(ACC_UP_STEP);
  localparam logic [AW-1:0] DN      = AW'(ACC_DN_STEP);

  logic [AW-1:0] acc_q, acc_n;
  logic          act_q, act_n;
  logic          start_q;

  always_comb begin
    if (sig) acc_n = (acc_q > ACC_MAX - UP) ? ACC_MAX : acc_q + UP;
    else     acc_n = (acc_q < DN) ? '0 : acc_q - DN;
    if (acc_q >= on_level)  act_n = 1'b1;
    else if (acc_q == '0)   act_n = 1'b0;
    else                    act_n = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      act_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      acc_q   <= acc_n;
      act_q   <= act_n;
      start_q <= act_n & ~act_q;
    end
  end

  assign active = act_q;
  assign start  = start_q;
endmodule

// File: rtl/sync_input_proc.sv
module sync_input_proc
  import sync_proc_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync_raw,
  input  logic          vsync_raw,
  input  logic          sel_separate,
  input  logic          det_refresh,
  input  logic [CW-1:0] cfg_min_width,
  input  logic [CW-1:0] cfg_holdoff,
  input  logic [AW-1:0] cfg_vx_on,
  output logic          line_strobe,
  output logic          frame_strobe,
  output logic          pll_inhibit,
  output logic          hpol_neg,
  output logic          vpol_neg,
  output logic          hv_seen,
  output logic          v_seen,
  output logic          vx_seen
);
  logic [NUM_INPUTS-1:0] raw_vec, norm_vec, pol_vec;
  logic                  h_strb, v_strb, vx_act, vx_start;
  logic                  hv_q, v_q, vx_q;
  logic                  hv_n, v_n, vx_n;
  sync_src_e             src;

  assign raw_vec[IDX_H] = hsync_raw;
  assign raw_vec[IDX_V] = vsync_raw;
  assign src = sync_src_e'(sel_separate);

  for (genvar gi = 0; gi < NUM_INPUTS; gi++) begin : g_cond
    sync_in_cond #(.CW(CW)) u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (raw_vec[gi]),
      .norm_out (norm_vec[gi]),
      .pol_neg  (pol_vec[gi])
    );
  end

  sync_pulse_qual #(.CW(CW)) u_hqual (
    .clk     (clk),
    .rst_n   (rst_n),
    .sig     (norm_vec[IDX_H]),
    .min_w   (cfg_min_width),
    .holdoff (cfg_holdoff),
    .strobe  (h_strb)
  );

  sync_pulse_qual #(.CW(CW)) u_vqual (
    .clk     (clk),
    .rst_n   (rst_n),
    .sig     (norm_vec[IDX_V]),
    .min_w   (cfg_min_width),
    .holdoff ({CW{1'b0}}),
    .strobe  (v_strb)
  );

  sync_vert_extract #(.AW(AW)) u_vx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig      (norm_vec[IDX_H]),
    .on_level (cfg_vx_on),
    .active   (vx_act),
    .start    (vx_start)
  );

  always_comb begin
    hv_n = det_refresh ? 1'b0 : (hv_q | h_strb);
    v_n  = det_refresh ? 1'b0 : (v_q  | v_strb);
    vx_n = det_refresh ? 1'b0 : (vx_q | vx_start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q <= 1'b0;
      v_q  <= 1'b0;
      vx_q <= 1'b0;
    end else begin
      hv_q <= hv_n;
      v_q  <= v_n;
      vx_q <= vx_n;
    end
  end

  assign line_strobe  = h_strb;
  assign frame_strobe = (src == SRC_SEPARATE) ? v_strb : vx_start;
  assign pll_inhibit  = (src == SRC_COMPOSITE) & vx_act;
  assign hpol_neg     = pol_vec[IDX_H];
  assign vpol_neg     = pol_vec[IDX_V];
  assign hv_seen      = hv_q;
  assign v_seen       = v_q;
  assign vx_seen      = vx_q;
endmodule

// File: rtl/sync_input_proc_chk.sv
module sync_input_proc_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_separate,
  input logic det_refresh,
  input logic line_strobe,
  input logic frame_strobe,
  input logic pll_inhibit,
  input logic hv_seen,
  input logic v_seen,
  input logic vx_seen
);
  AST_LINE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_strobe |=> !line_strobe); // R3

  AST_INHIBIT_SEPARATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sel_separate |-> !pll_inhibit); // R6

  AST_COMPOSITE_FRAME_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_separate && frame_strobe) |-> pll_inhibit); // R7

  AST_HV_SET_BY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_strobe && !det_refresh) |=> hv_seen); // R8

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_refresh && hv_seen && v_seen && vx_seen) |=> (hv_seen && v_seen && vx_seen)); // R8

  AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    det_refresh |=> (!hv_seen && !v_seen && !vx_seen)); // R9
endmodule

bind sync_input_proc sync_input_proc_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_separate (sel_separate),
  .det_refresh  (det_refresh),
  .line_strobe  (line_strobe),
  .frame_strobe (frame_strobe),
  .pll_inhibit  (pll_inhibit),
  .hv_seen      (hv_seen),
  .v_seen       (v_seen),
  .vx_seen      (vx_seen)
);

// File: tb/sync_input_proc_tb.sv
module sync_input_proc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int AW = 10;

  typedef struct packed {
    logic       neg;
    logic [7:0] width;
    logic [7:0] period;
    logic [7:0] exp_n;
    logic       exp_pol;
  } vec_t;

  // min width 4, holdoff 48, 8 counted lines per entry
  localparam vec_t VECS [6] = '{
    '{1'b0, 8'd6, 8'd64, 8'd8, 1'b0},   // positive narrow pulses
    '{1'b1, 8'd6, 8'd64, 8'd8, 1'b1},   // negative narrow pulses
    '{1'b0, 8'd2, 8'd64, 8'd0, 1'b0},   // glitches
    '{1'b0, 8'd4, 8'd64, 8'd8, 1'b0},   // exactly minimum width
    '{1'b0, 8'd3, 8'd64, 8'd0, 1'b0},   // one below minimum
    '{1'b0, 8'd6, 8'd40, 8'd4, 1'b0}    // spacing below holdoff
  };

  logic clk, rst_n, hsync_raw, vsync_raw, sel_separate, det_refresh;
  logic [CW-1:0] cfg_min_width, cfg_holdoff;
  logic [AW-1:0] cfg_vx_on;
  logic line_strobe, frame_strobe, pll_inhibit, hpol_neg, vpol_neg;
  logic hv_seen, v_seen, vx_seen;

  int n_cmp, n_bad, n_line, n_frame, n_inh;
  bit cnt_en, done;

  sync_input_proc #(.CW(CW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hsync_raw(hsync_raw), .vsync_raw(vsync_raw),
    .sel_separate(sel_separate), .det_refresh(det_refresh),
    .cfg_min_width(cfg_min_width), .cfg_holdoff(cfg_holdoff), .cfg_vx_on(cfg_vx_on),
    .line_strobe(line_strobe), .frame_strobe(frame_strobe), .pll_inhibit(pll_inhibit),
    .hpol_neg(hpol_neg), .vpol_neg(vpol_neg), .hv_seen(hv_seen), .v_seen(v_seen),
    .vx_seen(vx_seen)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: sample outputs at the falling edge, then leave inputs as set
  task automatic tick();
    @(negedge clk);
    if (cnt_en) begin
      if (line_strobe)  n_line++;
      if (frame_strobe) n_frame++;
      if (pll_inhibit)  n_inh++;
    end
  endtask

  task automatic clr_counts();
    n_line = 0; n_frame = 0; n_inh = 0;
  endtask

  task automatic h_line(input bit neg, input int w, input int p);
    for (int i = 0; i < p; i++) begin
      tick();
      hsync_raw = (i < w) ^ neg;
    end
  endtask

  task automatic v_frame(input bit neg, input int w, input int p);
    for (int i = 0; i < p; i++) begin
      tick();
      vsync_raw = (i < w) ^ neg;
    end
  endtask

  task automatic refresh();
    tick(); det_refresh = 1'b1;
    tick(); det_refresh = 1'b0;
  endtask

  // composite sequence: 4 normal lines, 8 broad lines (37.5 % duty), 12 normal
  task automatic composite_run();
    for (int i = 0; i < 4; i++)  h_line(1'b0, 6, 64);
    for (int i = 0; i < 8; i++)  h_line(1'b0, 24, 64);
    for (int i = 0; i < 12; i++) h_line(1'b0, 6, 64);
    tick();
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cnt_en = 0; done = 0;
    clr_counts();
    rst_n = 1'b0; hsync_raw = 1'b0; vsync_raw = 1'b0;
    sel_separate = 1'b1; det_refresh = 1'b0;
    cfg_min_width = 12'd4; cfg_holdoff = 12'd48; cfg_vx_on = 10'd100;
    repeat (5) tick();
    // R1: reset state
    chk("R1 line_strobe", line_strobe, 0);
    chk("R1 frame_strobe", frame_strobe, 0);
    chk("R1 pll_inhibit", pll_inhibit, 0);
    chk("R1 polarity", {hpol_neg, vpol_neg}, 0);
    chk("R1 flags", {hv_seen, v_seen, vx_seen}, 0);
    rst_n = 1'b1;
    repeat (5) tick();
    chk("R1 flags after release", {hv_seen, v_seen, vx_seen}, 0);

    // vector table: R2 polarity, R3 width, R4 holdoff, R8 flag
    for (int k = 0; k < 6; k++) begin
      for (int s = 0; s < 3; s++)
        h_line(VECS[k].neg, int'(VECS[k].width), int'(VECS[k].period));
      refresh();
      clr_counts();
      cnt_en = 1;
      for (int s = 0; s < 8; s++)
        h_line(VECS[k].neg, int'(VECS[k].width), int'(VECS[k].period));
      cnt_en = 0;
      chk($sformatf("R3 R4 vec%0d line strobes", k), n_line, int'(VECS[k].exp_n));
      chk($sformatf("R2 vec%0d hpol_neg", k), hpol_neg, int'(VECS[k].exp_pol));
      chk($sformatf("R8 vec%0d hv_seen", k), hv_seen, (VECS[k].exp_n != 0) ? 1 : 0);
    end

    // composite extraction, composite mode: R5 R6 R7 R8
    sel_separate = 1'b0;
    h_line(1'b0, 6, 64);
    refresh();
    clr_counts();
    cnt_en = 1;
    composite_run();
    cnt_en = 0;
    chk("R7 composite frame strobes", n_frame, 1);
    chk("R6 inhibit seen", (n_inh > 0) ? 1 : 0, 1);
    chk("R5 interval ended", pll_inhibit, 0);
    chk("R8 vx_seen composite", vx_seen, 1);

    // same sequence in separate mode: R6 R7 R8
    sel_separate = 1'b1;
    refresh();
    chk("R9 flags cleared", {hv_seen, v_seen, vx_seen}, 0);
    clr_counts();
    cnt_en = 1;
    composite_run();
    cnt_en = 0;
    chk("R6 no inhibit in separate", n_inh, 0);
    chk("R7 no frame strobe without vsync", n_frame, 0);
    chk("R8 vx_seen separate", vx_seen, 1);

    // narrow-only composite never extracts: R5
    sel_separate = 1'b0;
    refresh();
    clr_counts();
    cnt_en = 1;
    for (int i = 0; i < 20; i++) h_line(1'b0, 15, 64);
    cnt_en = 0;
    chk("R5 23pct duty no extraction", n_inh, 0);
    chk("R5 vx_seen stays 0", vx_seen, 0);

    // separate vertical input: R7 R2 R8
    sel_separate = 1'b1;
    hsync_raw = 1'b0;
    for (int i = 0; i < 2; i++) v_frame(1'b0, 10, 200);
    refresh();
    clr_counts();
    cnt_en = 1;
    for (int i = 0; i < 3; i++) v_frame(1'b0, 10, 200);
    cnt_en = 0;
    chk("R7 separate frame strobes", n_frame, 3);
    chk("R2 vpol positive", vpol_neg, 0);
    chk("R8 v_seen", v_seen, 1);

    for (int i = 0; i < 3; i++) v_frame(1'b1, 10, 200);
    refresh();
    clr_counts();
    cnt_en = 1;
    for (int i = 0; i < 3; i++) v_frame(1'b1, 10, 200);
    cnt_en = 0;
    chk("R7 negative vsync frame strobes", n_frame, 3);
    chk("R2 vpol negative", vpol_neg, 1);

    for (int i = 0; i < 3; i++) v_frame(1'b0, 2, 200);
    refresh();
    clr_counts();
    cnt_en = 1;
    for (int i = 0; i < 3; i++) v_frame(1'b0, 2, 200);
    cnt_en = 0;
    chk("R3 vsync glitch rejected", n_frame, 0);
    chk("R8 v_seen after glitches", v_seen, 0);

    // R9: flags set then refreshed
    for (int i = 0; i < 2; i++) h_line(1'b0, 6, 64);
    chk("R8 hv_seen before refresh", hv_seen, 1);
    refresh();
    tick();
    chk("R9 hv_seen cleared", hv_seen, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule